// File: doc/BRIEF.md
# I2C Target with Automatic Acknowledge

This block is a 7-bit-address I2C target for a system clock that runs much faster than SCL. SCL and SDA are brought in through a two-flop synchronizer. START and STOP conditions are decoded from the synchronized lines. The first byte after a START is compared against a programmable own address. On a match, the block either receives bytes from the controller or shifts out bytes from a transmit register. The read/write bit of that first byte picks the direction.

Acknowledge is fully automatic. The block acknowledges its address and every byte it receives, whatever the software-visible ACK/NAK control bit holds. When it is transmitting, a NAK from the controller marks the last byte. The block then lets go of SDA and stops sending. It still reports itself busy until the bus shows a STOP or a repeated START.

SDA is open-drain: the line is read through `sda_i`, and `sda_oe` pulls it low. Software reaches the block through a small register port: own address, a shared transmit/receive data register, status, and control.

Top module: `i2c_tgt_autoack`

## Requirements
- R1: After reset `sda_oe` is 0, status (select 2) reads 0x00 and the own-address register (select 0) reads 0x2A.
- R2: SDA falling while SCL is high (START) begins address reception. SDA rising while SCL is high (STOP) ends any session and clears status bit 0 (busy).
- R3: If bits 7:1 of the first byte after START equal the own address, the block pulls SDA low in the ninth clock. Control register (select 3) bit 0 has no effect on this.
- R4: On an address mismatch SDA is never driven until the next START or STOP. A later START that carries a matching address is acknowledged.
- R5: In receive mode every data byte is acknowledged in the clock right after its eighth bit, whatever control bit 0 holds. The byte is assembled MSB first and is read back at select 1.
- R6: Address bit 0 equal to 1 selects transmit. The byte last written to select 1 is shifted out MSB first, and SDA changes only while SCL is low.
- R7: A controller NAK after a transmitted byte ends the transfer. SDA is released and further clocks read as all ones.
- R8: After that NAK, busy (status bit 0) stays 1 until a STOP or a repeated START.
- R9: A repeated START during an addressed session returns the block to address reception. The own address and transmit data are kept.
- R10: Status bits: bit 1 is the direction (1 = transmit). Bit 2 is set by a received byte and cleared by reading select 1. Bit 3 is set by a transmitted byte and cleared by writing select 1. Bit 4 is set on an address match and cleared by reading status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_oe | output | 1 | 1 pulls SDA low |
| reg_sel | input | 2 | Register select: 0 own address, 1 data, 2 status, 3 control |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (clears read-sensitive flags) |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for the selected register |

## Verification
The hardest state to reach from the ports is the one after a controller NAK. In that state the block must stay busy yet silent while SCL keeps toggling. The bench reaches it by reading two bytes as controller and NAKing the second. It then clocks a full extra byte with SDA released and expects all ones, polls busy, and only then issues a STOP or repeated START. The repeated START mid-transfer is set up the same way, from a receive session and from the post-NAK state. The software-written new transmit byte is placed in the gap after the previous byte has been loaded.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;

  typedef enum logic [3:0] {
    ST_IDLE, ST_ADDR, ST_ADEC, ST_AACK,
    ST_RX,   ST_RDEC, ST_RACK,
    ST_TX,   ST_TACK, ST_IGN,  ST_DONE
  } tgt_state_e;

  localparam logic [1:0] SEL_OWN  = 2'd0;
  localparam logic [1:0] SEL_DATA = 2'd1;
  localparam logic [1:0] SEL_STAT = 2'd2;
  localparam logic [1:0] SEL_CTRL = 2'd3;

  // first-byte layout: address in 7:1, direction in 0
  function automatic logic addr_hit(input logic [7:0] frame, input logic [6:0] own);
    return frame[7:1] == own;
  endfunction

  function automatic logic [7:0] shift_in(input logic [7:0] sh, input logic b);
    return {sh[6:0], b};
  endfunction

endpackage

// File: rtl/i2c_tgt_sync.sv
module i2c_tgt_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);
  logic [STAGES-1:0] scl_ff, sda_ff;
  logic scl_q, sda_q;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          scl_ff[g] <= 1'b1;
          sda_ff[g] <= 1'b1;
        end else begin
          scl_ff[g] <= (g == 0) ? scl_i : scl_ff[(g == 0) ? 0 : g-1];
          sda_ff[g] <= (g == 0) ? sda_i : sda_ff[(g == 0) ? 0 : g-1];
        end
      end
    end
  endgenerate

  assign scl_s = scl_ff[STAGES-1];
  assign sda_s = sda_ff[STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  assign scl_rise  =  scl_s & ~scl_q;
  assign scl_fall  = ~scl_s &  scl_q;
  assign start_evt =  scl_s &  scl_q &  sda_q & ~sda_s;
  assign stop_evt  =  scl_s &  scl_q & ~sda_q &  sda_s;
endmodule

// File: rtl/i2c_tgt_engine.sv
module i2c_tgt_engine
  import i2c_tgt_pkg::*;
#(
  parameter int unsigned AW = 7,
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sda_s,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic          start_evt,
  input  logic          stop_evt,
  input  logic [AW-1:0] own_addr,
  input  logic [DW-1:0] tx_data,
  output logic          sda_oe,
  output logic [DW-1:0] rx_byte,
  output logic          rx_stb,
  output logic          tx_stb,
  output logic          hit_stb,
  output logic          busy,
  output logic          dir_tx,
  output logic          addr_phase,
  output logic          ack_phase,
  output logic          ignoring,
  output logic          nak_done
);
  localparam int unsigned CW = $clog2(DW);
  localparam logic [CW-1:0] LAST = CW'(DW - 1);

  tgt_state_e    state;
  logic [CW-1:0] cnt;
  logic [DW-1:0] sh, tx_sh;
  logic          mack;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      sh      <= '0;
      tx_sh   <= '0;
      rx_byte <= '0;
      mack    <= 1'b0;
      busy    <= 1'b0;
      dir_tx  <= 1'b0;
      rx_stb  <= 1'b0;
      tx_stb  <= 1'b0;
      hit_stb <= 1'b0;
    end else begin
      rx_stb  <= 1'b0;
      tx_stb  <= 1'b0;
      hit_stb <= 1'b0;
      if (stop_evt) begin
        state <= ST_IDLE;
        busy  <= 1'b0;
      end else if (start_evt) begin
        state <= ST_ADDR;
        cnt   <= '0;
        busy  <= 1'b0;
      end else begin
        unique case (state)
          ST_ADDR, ST_RX: if (scl_rise) begin
            sh <= shift_in(sh, sda_s);
            if (cnt == LAST) begin
              cnt   <= '0;
              state <= (state == ST_ADDR) ? ST_ADEC : ST_RDEC;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          ST_ADEC: if (scl_fall) begin
            if (addr_hit(sh, own_addr)) begin
              state   <= ST_AACK;
              busy    <= 1'b1;
              dir_tx  <= sh[0];
              hit_stb <= 1'b1;
            end else begin
              state <= ST_IGN;
            end
          end
          ST_AACK: if (scl_fall) begin
            cnt <= '0;
            if (dir_tx) begin
              state <= ST_TX;
              tx_sh <= tx_data;
            end else begin
              state <= ST_RX;
            end
          end
          ST_RDEC: if (scl_fall) begin
            state   <= ST_RACK;
            rx_byte <= sh;
            rx_stb  <= 1'b1;
          end
          ST_RACK: if (scl_fall) state <= ST_RX;
          ST_TX: if (scl_fall) begin
            tx_sh <= {tx_sh[DW-2:0], 1'b0};
            if (cnt == LAST) begin
              cnt    <= '0;
              state  <= ST_TACK;
              tx_stb <= 1'b1;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          ST_TACK: begin
            if (scl_rise) begin
              mack <= ~sda_s;
            end else if (scl_fall) begin
              if (mack) begin
                state <= ST_TX;
                tx_sh <= tx_data;
              end else begin
                state <= ST_DONE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign addr_phase = (state == ST_ADDR);
  assign ack_phase  = (state == ST_AACK) | (state == ST_RACK);
  assign ignoring   = (state == ST_IGN);
  assign nak_done   = (state == ST_DONE);
  assign sda_oe     = ack_phase | ((state == ST_TX) & ~tx_sh[DW-1]);
endmodule

// File: rtl/i2c_tgt_autoack.sv
module i2c_tgt_autoack
  import i2c_tgt_pkg::*;
#(
  parameter int unsigned   AW          = 7,
  parameter int unsigned   DW          = 8,
  parameter int unsigned   SYNC_STAGES = 2,
  parameter logic [AW-1:0] RESET_ADDR  = 7'h2A
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_i,
  input  logic          sda_i,
  output logic          sda_oe,
  input  logic [1:0]    reg_sel,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata
);
  logic scl_s, sda_s, scl_rise, scl_fall, start_evt, stop_evt;
  logic rx_stb, tx_stb, hit_stb, busy, dir_tx;
  logic addr_phase, ack_phase, ignoring, nak_done;
  logic [DW-1:0] rx_byte, tx_data;
  logic [AW-1:0] own_addr;
  logic ctrl_acknak, rx_full, tx_done, hit;

  i2c_tgt_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_evt(start_evt), .stop_evt(stop_evt)
  );

  i2c_tgt_engine #(.AW(AW), .DW(DW)) u_eng (
    .clk(clk), .rst_n(rst_n), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_evt(start_evt), .stop_evt(stop_evt),
    .own_addr(own_addr), .tx_data(tx_data),
    .sda_oe(sda_oe), .rx_byte(rx_byte), .rx_stb(rx_stb), .tx_stb(tx_stb),
    .hit_stb(hit_stb), .busy(busy), .dir_tx(dir_tx),
    .addr_phase(addr_phase), .ack_phase(ack_phase),
    .ignoring(ignoring), .nak_done(nak_done)
  );

  logic wr_data, rd_data, rd_stat;
  assign wr_data = reg_wr & (reg_sel == SEL_DATA);
  assign rd_data = reg_rd & (reg_sel == SEL_DATA);
  assign rd_stat = reg_rd & (reg_sel == SEL_STAT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      own_addr    <= RESET_ADDR;
      tx_data     <= '0;
      ctrl_acknak <= 1'b0;
      rx_full     <= 1'b0;
      tx_done     <= 1'b0;
      hit         <= 1'b0;
    end else begin
      if (reg_wr && reg_sel == SEL_OWN)  own_addr    <= reg_wdata[AW-1:0];
      if (wr_data)                       tx_data     <= reg_wdata;
      if (reg_wr && reg_sel == SEL_CTRL) ctrl_acknak <= reg_wdata[0];
      if (rx_stb)       rx_full <= 1'b1;
      else if (rd_data) rx_full <= 1'b0;
      if (tx_stb)       tx_done <= 1'b1;
      else if (wr_data) tx_done <= 1'b0;
      if (hit_stb)      hit <= 1'b1;
      else if (rd_stat) hit <= 1'b0;
    end
  end

  // the ACK/NAK control bit is stored for software only; acknowledge is automatic
  always_comb begin
    unique case (reg_sel)
      SEL_OWN:  reg_rdata = {{(DW-AW){1'b0}}, own_addr};
      SEL_DATA: reg_rdata = rx_byte;
      SEL_STAT: reg_rdata = {{(DW-5){1'b0}}, hit, tx_done, rx_full, dir_tx, busy};
      default:  reg_rdata = {{(DW-1){1'b0}}, ctrl_acknak};
    endcase
  end
endmodule

// File: rtl/i2c_tgt_chk.sv
module i2c_tgt_chk (
  input logic clk,
  input logic rst_n,
  input logic scl_s,
  input logic sda_oe,
  input logic start_evt,
  input logic stop_evt,
  input logic busy,
  input logic addr_phase,
  input logic ack_phase,
  input logic ignoring,
  input logic nak_done
);
  // R6
  oe_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(sda_oe) && !$past(start_evt) && !$past(stop_evt)) |-> !scl_s);

  // R2
  stop_clears_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt |=> !busy);

  // R9
  rstart_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> addr_phase);

  // R4
  ignore_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ignoring |-> !sda_oe);

  // R3
  ack_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_phase |-> sda_oe);

  // R8
  nak_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    nak_done |-> (busy && !sda_oe));
endmodule

bind i2c_tgt_autoack i2c_tgt_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_oe(sda_oe),
  .start_evt(start_evt), .stop_evt(stop_evt), .busy(busy),
  .addr_phase(addr_phase), .ack_phase(ack_phase),
  .ignoring(ignoring), .nak_done(nak_done)
);

// File: tb/tb_i2c_tgt_autoack.sv
module tb_i2c_tgt_autoack;
  localparam int CLK_P = 10;
  localparam int Q     = 10;
  localparam logic [6:0] OWN = 7'h2A;

  // {addr[15:9], data[8:1], expect_ack[0]}
  localparam logic [15:0] VEC [0:5] = '{
    {7'h2A, 8'hA5, 1'b1}, {7'h2A, 8'h00, 1'b1}, {7'h2B, 8'h3C, 1'b0},
    {7'h2A, 8'hFF, 1'b1}, {7'h55, 8'h81, 1'b0}, {7'h2A, 8'h5A, 1'b1}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic [1:0] reg_sel = 2'd0;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [7:0] reg_wdata = 8'h00, reg_rdata;
  logic sda_oe;
  wire  sda_line = sda_m & ~sda_oe;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  i2c_tgt_autoack dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe),
    .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic wq(); repeat (Q) @(negedge clk); endtask

  task automatic bus_start();
    sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); sda_m = 1'b0; wq(); scl_m = 1'b0; wq();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wq(); scl_m = 1'b1; wq(); sda_m = 1'b1; wq();
  endtask

  task automatic bit_xfer(input logic b, output logic got);
    sda_m = b; wq(); scl_m = 1'b1; wq(); got = sda_line; wq(); scl_m = 1'b0; wq();
  endtask

  task automatic wr_byte(input logic [7:0] b, output logic ack);
    logic g;
    for (int i = 7; i >= 0; i--) bit_xfer(b[i], g);
    bit_xfer(1'b1, g);
    ack = ~g;
    sda_m = 1'b1;
  endtask

  task automatic rd_byte(input logic mack, output logic [7:0] d);
    logic g;
    for (int i = 7; i >= 0; i--) begin
      bit_xfer(1'b1, g);
      d[i] = g;
    end
    bit_xfer(~mack, g);
    sda_m = 1'b1;
  endtask

  task automatic reg_write(input logic [1:0] s, input logic [7:0] d);
    @(negedge clk); reg_sel = s; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic reg_read(input logic [1:0] s, output logic [7:0] d);
    @(negedge clk); reg_sel = s; reg_rd = 1'b1; #1 d = reg_rdata;
    @(negedge clk); reg_rd = 1'b0;
  endtask

  task automatic report();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    report();
  end

  initial begin
    logic a, a2;
    logic [7:0] d;
    logic [15:0] v;
    repeat (5) @(negedge clk);
    // R1 reset state
    chk("R1 oe", {7'd0, sda_oe}, 8'h00);
    reg_read(2'd2, d); chk("R1 status", d, 8'h00);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    reg_read(2'd0, d); chk("R1 own", d, {1'b0, OWN});

    // vector table: write transfers, matching and mismatching
    for (int k = 0; k < 6; k++) begin
      v = VEC[k];
      bus_start();
      wr_byte({v[15:9], 1'b0}, a);
      chk("R3 addr ack", {7'd0, a}, {7'd0, v[0]});
      wr_byte(v[8:1], a2);
      if (v[0]) begin
        chk("R5 data ack", {7'd0, a2}, 8'h01);
        reg_read(2'd2, d); chk("R10 status rx", d & 8'h17, 8'h15);
        reg_read(2'd1, d); chk("R5 rx byte", d, v[8:1]);
        reg_read(2'd2, d); chk("R10 rx cleared", d & 8'h07, 8'h01);
      end else begin
        chk("R4 no drive", {7'd0, a2}, 8'h00);
      end
      bus_stop();
      reg_read(2'd2, d); chk("R2 idle after stop", d & 8'h01, 8'h00);
    end

    // R3 R5: control bit set to NAK has no effect
    reg_write(2'd3, 8'h01);
    bus_start();
    wr_byte({OWN, 1'b0}, a); chk("R3 ack with ctrl nak", {7'd0, a}, 8'h01);
    wr_byte(8'h69, a);       chk("R5 ack with ctrl nak", {7'd0, a}, 8'h01);
    bus_stop();
    reg_read(2'd3, d); chk("R3 ctrl readback", d, 8'h01);
    reg_read(2'd1, d); chk("R5 rx with ctrl nak", d, 8'h69);

    // R4: mismatch, then repeated START with matching address
    bus_start();
    wr_byte(8'h10, a); chk("R4 mismatch", {7'd0, a}, 8'h00);
    bus_start();
    wr_byte({OWN, 1'b0}, a); chk("R4 match after start", {7'd0, a}, 8'h01);
    bus_stop();

    // R6 R7 R8 R10: transmit, controller NAK, stay busy
    reg_write(2'd1, 8'hC3);
    bus_start();
    wr_byte({OWN, 1'b1}, a); chk("R6 addr ack tx", {7'd0, a}, 8'h01);
    reg_write(2'd1, 8'h96);
    rd_byte(1'b1, d); chk("R6 tx byte0", d, 8'hC3);
    reg_read(2'd2, d); chk("R10 tx status", d & 8'h0B, 8'h0B);
    rd_byte(1'b0, d); chk("R6 tx byte1", d, 8'h96);
    reg_read(2'd2, d); chk("R8 busy after nak", d & 8'h01, 8'h01);
    rd_byte(1'b0, d); chk("R7 released", d, 8'hFF);
    reg_read(2'd2, d); chk("R8 still busy", d & 8'h01, 8'h01);
    bus_stop();
    reg_read(2'd2, d); chk("R8 stop clears busy", d & 8'h01, 8'h00);

    // R8 R9: repeated START after NAK, then receive
    reg_write(2'd1, 8'h3E);
    bus_start();
    wr_byte({OWN, 1'b1}, a);
    rd_byte(1'b0, d); chk("R6 tx single", d, 8'h3E);
    bus_start();
    reg_read(2'd2, d); chk("R8 rstart clears busy", d & 8'h01, 8'h00);
    wr_byte({OWN, 1'b0}, a); chk("R9 addr after rstart", {7'd0, a}, 8'h01);
    wr_byte(8'h7E, a);       chk("R9 data ack", {7'd0, a}, 8'h01);
    reg_read(2'd1, d);       chk("R9 rx", d, 8'h7E);
    // R9: repeated START mid-receive, switch to transmit
    reg_write(2'd1, 8'h4B);
    bus_start();
    wr_byte({OWN, 1'b1}, a); chk("R9 rstart tx ack", {7'd0, a}, 8'h01);
    rd_byte(1'b0, d);        chk("R9 tx kept", d, 8'h4B);
    bus_stop();
    reg_read(2'd0, d); chk("R9 own kept", d, {1'b0, OWN});

    // R3 R10: new own address, hit flag cleared by status read
    reg_write(2'd0, 8'h11);
    reg_read(2'd2, d);
    bus_start();
    wr_byte({7'h11, 1'b0}, a); chk("R3 new own", {7'd0, a}, 8'h01);
    bus_stop();
    reg_read(2'd2, d); chk("R10 hit set", d & 8'h10, 8'h10);
    reg_read(2'd2, d); chk("R10 hit cleared", d & 8'h10, 8'h00);
    chk("R2 oe idle", {7'd0, sda_oe}, 8'h00);
    report();
  end
endmodule